// File: doc/BRIEF.md
# Snooping Write-Through Data Cache

This block is a small direct-mapped data cache for one core that shares a broadcast memory bus with other caches and a DMA master. The core issues single-word loads and stores. Loads that find a valid line answer from the cache without touching the bus. Loads that miss fetch the word over the bus, fill the line and then answer. Every store goes out on the bus as a write to memory. A store that hits also refreshes the local copy. A store that misses leaves the cache unchanged.

The cache watches every transaction on the shared bus through a snoop port. When another master writes a word that the cache holds, the cache drops its copy, so a later load fetches the new value from memory. Reads by other masters do not disturb any line, so any number of caches can share a word for reading. The cache's own writes, seen on the snoop port, are ignored. Bus ownership is obtained with a request/grant handshake. The memory side answers each granted transaction with a one-cycle acknowledge.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset, `core_busy`, `core_done` and `bus_req` are low and every line is invalid, so the first load of any address goes to the bus.
- R2: A load miss raises `bus_req` with `bus_we`=0 and `bus_addr` equal to the load address. After `bus_ack`, `core_done` pulses in the next cycle with `core_rdata` equal to the `bus_rdata` sampled with the acknowledge. The line is then filled.
- R3: A load that hits raises no bus request. `core_done` rises two cycles after the cycle in which `core_req` was sampled, and returns the cached word.
- R4: Every store raises `bus_req` with `bus_we`=1 and `bus_addr`/`bus_wdata` equal to the store's address and data. `core_done` pulses in the cycle after `bus_ack`.
- R5: A store that hits a valid line updates that line, so the next load of that address hits and returns the stored data.
- R6: A store that misses allocates no line, so the next load of that address goes to the bus.
- R7: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values into the next cycle.
- R8: A snoop with `snp_valid`=1, `snp_we`=1 and `snp_master` not equal to the cache's own ID clears the line whose stored tag matches `snp_addr`. The line is invalid from the next cycle, and the next load of that address goes to the bus.
- R9: Snooped reads (`snp_we`=0), snooped writes carrying the cache's own ID, and snooped writes to the same index with a different tag leave the line valid.
- R10: If a remote snooped write to the same address coincides with a line fill, the line ends invalid. The core still receives the fetched data, and the next load goes to the bus.
- R11: The line index is `addr[IDX_W-1:0]` and the tag is the remaining upper bits. A load miss to an index that already holds another tag replaces it, so the earlier address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | One-cycle request pulse from the core, allowed only while `core_busy` is low |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Word address of the access |
| core_wdata | input | DATA_W | Store data |
| core_busy | output | 1 | High while an access is in progress |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load result, valid with `core_done` (zero for stores) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Grant; the transaction is on the bus in this cycle |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | ADDR_W | Transaction word address |
| bus_wdata | output | DATA_W | Write-through data |
| bus_ack | input | 1 | Memory acknowledge, at least one cycle after the grant |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| snp_valid | input | 1 | A transaction is visible on the shared bus |
| snp_we | input | 1 | The snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_master | input | ID_W | ID of the master that owns the snooped transaction |

## Verification
Directed accesses cover a cold load, a repeated load and stores to cached and uncached words. Whether `bus_req` rises, together with the completion latency, tells a hit from a miss, and this also separates write-allocate from no-allocate. Snoop patterns vary one attribute at a time: remote write, remote read, own-ID write, and a write to the same index with a different tag. Each pattern is followed by a load, and the load shows whether the line was dropped. A remote write timed exactly on a fill acknowledge, and a second tag loaded into an occupied index, probe the collision priority and direct-mapped replacement. The grant is held back for several cycles to expose any drift in the pending request.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_BUS  = 2'd2,
    ST_WAIT = 2'd3
  } snc_state_e;

endpackage

// File: rtl/snc_line_store.sv
module snc_line_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_master,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic [LINES-1:0]  line_valid,
  output logic              inv_evt,
  output logic              kill_evt
);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  snp_match;
  logic [LINES-1:0]  fill_kill;

  wire remote_wr = snp_valid && snp_we && (snp_master != MY_ID);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    wire sel_g   = (idx_of(look_addr) == IDX_W'(g));
    wire snoop_g = remote_wr && (idx_of(snp_addr) == IDX_W'(g));
    wire fill_g  = fill_en && sel_g;

    assign snp_match[g] = snoop_g && valid_q[g] && (tag_q[g] == tag_of(snp_addr));
    assign fill_kill[g] = fill_g && snoop_g && (tag_of(snp_addr) == tag_of(look_addr));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (fill_g) begin
        valid_q[g] <= !fill_kill[g];
        tag_q[g]   <= tag_of(look_addr);
        data_q[g]  <= fill_data;
      end else begin
        if (snp_match[g]) valid_q[g] <= 1'b0;
        if (upd_en && sel_g) data_q[g] <= upd_data;
      end
    end
  end

  assign hit        = valid_q[idx_of(look_addr)] && (tag_q[idx_of(look_addr)] == tag_of(look_addr));
  assign hit_data   = data_q[idx_of(look_addr)];
  assign line_valid = valid_q;
  assign inv_evt    = |snp_match;
  assign kill_evt   = |fill_kill;

endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_busy,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              hit,
  input  logic [DATA_W-1:0] hit_data,
  output logic [ADDR_W-1:0] req_addr,
  output logic              fill_en,
  output logic              upd_en,
  output logic              hit_done,
  output logic              wait_st
);

  snc_state_e        state_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  assign hit_done = (state_q == ST_LOOK) && !we_q && hit;
  assign wait_st  = (state_q == ST_WAIT);
  wire   ack_now  = wait_st && bus_ack;
  assign fill_en  = ack_now && !we_q;
  assign upd_en   = ack_now && we_q && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (core_req) begin
          we_q    <= core_we;
          addr_q  <= core_addr;
          wdata_q <= core_wdata;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (hit_done) begin
          done_q  <= 1'b1;
          rdata_q <= hit_data;
          state_q <= ST_IDLE;
        end else begin
          state_q <= ST_BUS;
        end
        ST_BUS: if (bus_gnt) state_q <= ST_WAIT;
        ST_WAIT: if (bus_ack) begin
          done_q  <= 1'b1;
          rdata_q <= we_q ? '0 : bus_rdata;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign core_busy  = (state_q != ST_IDLE);
  assign core_done  = done_q;
  assign core_rdata = rdata_q;
  assign bus_req    = (state_q == ST_BUS);
  assign bus_we     = we_q;
  assign bus_addr   = addr_q;
  assign bus_wdata  = wdata_q;
  assign req_addr   = addr_q;

endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_busy,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_master
);

  logic              hit;
  logic [DATA_W-1:0] hit_data;
  logic [ADDR_W-1:0] req_addr;
  logic              fill_en;
  logic              upd_en;
  logic              hit_done;
  logic              wait_st;
  logic [LINES-1:0]  line_valid;
  logic              inv_evt;
  logic              kill_evt;

  snc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_busy(core_busy), .core_done(core_done), .core_rdata(core_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .hit(hit), .hit_data(hit_data), .req_addr(req_addr),
    .fill_en(fill_en), .upd_en(upd_en), .hit_done(hit_done), .wait_st(wait_st)
  );

  snc_line_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .look_addr(req_addr), .fill_en(fill_en), .fill_data(bus_rdata),
    .upd_en(upd_en), .upd_data(bus_wdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_master(snp_master),
    .hit(hit), .hit_data(hit_data), .line_valid(line_valid),
    .inv_evt(inv_evt), .kill_evt(kill_evt)
  );

endmodule

// File: rtl/snc_checker.sv
module snc_checker #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_busy,
  input logic              core_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] snp_addr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              fill_en,
  input logic              hit_done,
  input logic              wait_st,
  input logic [LINES-1:0]  line_valid,
  input logic              inv_evt,
  input logic              kill_evt
);

  logic [IDX_W-1:0] snp_idx_q;
  always_ff @(posedge clk) begin
    if (!rst_n) snp_idx_q <= '0;
    else        snp_idx_q <= snp_addr[IDX_W-1:0];
  end

  wire fill_here = fill_en && (req_addr[IDX_W-1:0] == snp_addr[IDX_W-1:0]);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !core_busy |-> !bus_req);

  p_ack_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && bus_ack) |=> (core_done && !core_busy));

  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_done |=> (core_done && !bus_req));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  p_snoop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_evt && !fill_here) |=> !line_valid[snp_idx_q]);

  p_kill_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kill_evt |=> !line_valid[snp_idx_q]);

endmodule

bind snoop_wt_cache snc_checker #(.ADDR_W(ADDR_W), .LINES(LINES)) i_snc_checker (
  .clk(clk), .rst_n(rst_n), .core_busy(core_busy), .core_done(core_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .snp_addr(snp_addr), .req_addr(req_addr), .fill_en(fill_en),
  .hit_done(hit_done), .wait_st(wait_st), .line_valid(line_valid),
  .inv_evt(inv_evt), .kill_evt(kill_evt)
);

// File: tb/test_snoop_wt_cache.sv
module test_snoop_wt_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_req = 1'b0;
  logic        core_we = 1'b0;
  logic [15:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic        core_busy;
  logic        core_done;
  logic [31:0] core_rdata;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic        bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        snp_valid = 1'b0;
  logic        snp_we = 1'b0;
  logic [15:0] snp_addr = '0;
  logic [1:0]  snp_master = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [31:0] mem [int];

  always #4 clk = ~clk;

  snoop_wt_cache i_snoop_wt_cache (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_busy(core_busy), .core_done(core_done), .core_rdata(core_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr), .snp_master(snp_master)
  );

  function automatic logic [31:0] mem_rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {~a, a} ^ 32'h3C3C_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One core access with a simple bus/memory model; optional remote write at the ack cycle.
  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input int gdel, input int adel, input bit collide,
                        output logic [31:0] rd, output bit used, output int lat, output int ack_gap);
    int  cyc = 0, gcnt = 0, acnt = 0, ack_cyc = -1;
    bit  granted = 0, acked = 0;
    used = 0;
    @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
    @(negedge clk);
    core_req = 1'b0;
    cyc = 1;
    while (cyc < 200) begin
      bus_gnt = 1'b0; bus_ack = 1'b0; snp_valid = 1'b0;
      if (core_done) break;
      if (bus_req) begin
        used = 1;
        chk(bus_we == we && bus_addr == a && (!we || bus_wdata == wd),
            "R4 and R7 bus fields", {15'd0, bus_we, bus_addr}, {15'd0, we, a});
        if (gcnt == gdel) begin bus_gnt = 1'b1; granted = 1; end
        else gcnt++;
      end else if (granted && !acked) begin
        if (acnt == adel) begin
          bus_ack = 1'b1;
          bus_rdata = we ? 32'hDEAD_BEEF : mem_rd(a);
          acked = 1; ack_cyc = cyc;
          if (we) mem[int'(a)] = wd;
          if (collide) begin
            snp_valid = 1'b1; snp_we = 1'b1; snp_addr = a; snp_master = 2'd2;
            mem[int'(a)] = mem_rd(a) + 32'h0101_0101;
          end
        end else acnt++;
      end
      @(negedge clk);
      cyc++;
    end
    rd = core_rdata;
    lat = cyc;
    ack_gap = acked ? cyc - ack_cyc : -1;
    chk(cyc < 200, "R2 access completes", cyc, 0);
  endtask

  task automatic snoop(input logic we, input logic [15:0] a, input logic [1:0] id);
    @(negedge clk);
    snp_valid = 1'b1; snp_we = we; snp_addr = a; snp_master = id;
    @(negedge clk);
    snp_valid = 1'b0;
    if (we && id != 2'd0) mem[int'(a)] = mem_rd(a) + 32'h0000_1111;
  endtask

  // Load helpers
  task automatic load_expect_miss(input logic [15:0] a, input string req);
    logic [31:0] rd, exp; bit used; int lat, gap;
    exp = mem_rd(a);
    access(1'b0, a, '0, 2, 1, 0, rd, used, lat, gap);
    chk(used, {req, " load goes to bus"}, {31'd0, used}, 1);
    chk(rd == exp, {req, " miss data"}, rd, exp);
    chk(gap == 1, "R2 done one cycle after ack", gap, 1);
  endtask

  task automatic load_expect_hit(input logic [15:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; bit used; int lat, gap;
    access(1'b0, a, '0, 0, 0, 0, rd, used, lat, gap);
    chk(!used, {req, " hit raises no bus_req"}, {31'd0, used}, 0);
    chk(lat == 2, "R3 hit latency", lat, 2);
    chk(rd == exp, {req, " hit data"}, rd, exp);
  endtask

  task automatic store(input logic [15:0] a, input logic [31:0] wd);
    logic [31:0] rd; bit used; int lat, gap;
    access(1'b1, a, wd, 3, 1, 0, rd, used, lat, gap);
    chk(used, "R4 store written through", {31'd0, used}, 1);
    chk(gap == 1, "R4 store done after ack", gap, 1);
  endtask

  localparam logic [15:0] A_ADR = 16'h0013, F_ADR = 16'h0123, B_ADR = 16'h0045;
  localparam logic [15:0] C_ADR = 16'h0206, D_ADR = 16'h0307, D_ALT = 16'h0417;
  localparam logic [15:0] E_ADR = 16'h0508;

  task automatic t_reset;
    @(negedge clk);
    chk(!core_busy && !core_done && !bus_req, "R1 reset outputs",
        {29'd0, core_busy, core_done, bus_req}, 0);
  endtask

  task automatic t_cold_and_hit;
    load_expect_miss(A_ADR, "R1 R2 cold");
    load_expect_hit(A_ADR, mem_rd(A_ADR), "R3");
  endtask

  task automatic t_store_hit;
    store(A_ADR, 32'h1234_5678);
    load_expect_hit(A_ADR, 32'h1234_5678, "R5");
  endtask

  task automatic t_store_miss;
    store(B_ADR, 32'hCAFE_0045);
    load_expect_miss(B_ADR, "R6");
  endtask

  task automatic t_remote_inv;
    load_expect_miss(C_ADR, "R8 prep");
    snoop(1'b1, C_ADR, 2'd1);
    load_expect_miss(C_ADR, "R8");
  endtask

  task automatic t_snoop_ignored;
    load_expect_miss(D_ADR, "R9 prep");
    snoop(1'b0, D_ADR, 2'd3);
    snoop(1'b1, D_ADR, 2'd0);
    snoop(1'b1, D_ALT, 2'd1);
    load_expect_hit(D_ADR, mem_rd(D_ADR), "R9");
  endtask

  task automatic t_collide;
    logic [31:0] rd, exp; bit used; int lat, gap;
    exp = mem_rd(E_ADR);
    access(1'b0, E_ADR, '0, 1, 2, 1, rd, used, lat, gap);
    chk(rd == exp, "R10 core gets fetched data", rd, exp);
    load_expect_miss(E_ADR, "R10 line invalid after");
  endtask

  task automatic t_conflict;
    load_expect_miss(F_ADR, "R11 new tag");
    load_expect_hit(F_ADR, mem_rd(F_ADR), "R11");
    load_expect_miss(A_ADR, "R11 evicted");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_and_hit();
    t_store_hit();
    t_store_miss();
    t_remote_inv();
    t_snoop_ignored();
    t_collide();
    t_conflict();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule